// File: doc/BRIEF.md
# Serial DAC Control Word Receiver

This block takes control words for a DAC from a serial line that is clocked by the locally generated serial clock. That clock also drives the output serializer. A word starts when the frame-sync input is seen high at a rising clock edge while the receiver is idle. The 16 rising edges that follow each take one data bit, most significant bit first.

Once the last bit is in, bits 11:0 of the word go to the DAC as an unsigned code, and a valid strobe is raised for one cycle. Bits 15:12 are dropped. The receiver does not depend on the output framing. The only thing the two share is the clock.

The DAC code output is a valid-only stream and has no ready signal, because the serial sender cannot be paused. A word is presented for exactly one cycle, and the consumer must take it in that cycle. Between strobes the code holds its last value, so a consumer that only needs the level can read `dac_code` at any time.

Top module: `dac_ctrl_rx`

## Requirements
- R1: While reset is asserted, and on its release, `dac_code` is 0 and `dac_valid` is 0.
- R2: When `frame_sync` is 1 at a rising edge while the receiver is idle, a capture starts. The next 16 rising edges sample `ser_data`, and the first sampled bit becomes word bit 15 (MSB first).
- R3: `dac_code` takes word bits 11:0 unsigned. Word bits 15:12 have no effect on any output.
- R4: `dac_valid` is 1 for exactly one cycle, in the cycle after the 16th data edge. `dac_code` takes the new value in that same cycle. At no other time is `dac_valid` 1.
- R5: While `dac_valid` is 0, `dac_code` keeps its previous value.
- R6: A `frame_sync` of 1 at any data edge of a capture, including the 16th, is ignored. It neither restarts nor extends the word.
- R7: A `frame_sync` of 1 at the edge right after the 16th data edge starts the next word, so words can arrive back to back every 17 cycles.
- R8: With `frame_sync` held at 0, `dac_valid` stays 0 and `dac_code` does not change, whatever `ser_data` does.
- R9: There is no back-pressure. Every completed word is presented, and consecutive strobes are at least 17 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, shared with the output serializer |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Frame sync; a high level at a rising edge starts a word when idle |
| ser_data | input | 1 | Serial data, MSB first |
| dac_code | output | 12 | Unsigned DAC code from word bits 11:0 |
| dac_valid | output | 1 | One-cycle strobe when `dac_code` takes a new word |

## Verification
The properties assume that `frame_sync` and `ser_data` are synchronous to `clk` and settle well away from the rising edge. They also assume that reset is held across at least one rising edge before it is released. The stimulus meets this by changing every input only on falling edges. Reset is held for several cycles before any word is sent. The strobe-spacing property depends on the fixed word length, so the bench never cuts a word short. It covers idle, noisy-sync and back-to-back cases only with whole 16-bit words.

// File: rtl/dac_ctrl_rx_pkg.sv
package dac_ctrl_rx_pkg;
  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_SHIFT = 1'b1
  } rx_state_t;
endpackage

// File: rtl/dac_ctrl_rx_frame.sv
module dac_ctrl_rx_frame
  import dac_ctrl_rx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_sync,
  output logic shift_en,
  output logic word_done
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  rx_state_t        state;
  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      bit_cnt <= '0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          if (frame_sync) begin
            state   <= RX_SHIFT;
            bit_cnt <= '0;
          end
        end
        RX_SHIFT: begin
          if (bit_cnt == LAST) begin
            state   <= RX_IDLE;
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign shift_en  = (state == RX_SHIFT);
  assign word_done = shift_en && (bit_cnt == LAST);
endmodule

// File: rtl/dac_ctrl_rx_shift.sv
module dac_ctrl_rx_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word_full
);
  logic [WORD_W-2:0] shreg;

  assign word_full = {shreg, bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else if (shift_en) shreg <= word_full[WORD_W-2:0];
  end
endmodule

// File: rtl/dac_ctrl_rx_out.sv
module dac_ctrl_rx_out #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [CODE_W-1:0] code,
  output logic              valid
);
  generate
    if (WORD_W > CODE_W) begin : g_drop
      logic unused_hi;
      assign unused_hi = ^word[WORD_W-1:CODE_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= load;
      if (load) code <= word[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/dac_ctrl_rx.sv
module dac_ctrl_rx #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_sync,
  input  logic              ser_data,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_valid
);
  logic              shift_en;
  logic              word_done;
  logic [WORD_W-1:0] word_full;

  dac_ctrl_rx_frame #(.WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .shift_en(shift_en), .word_done(word_done)
  );

  dac_ctrl_rx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .bit_in(ser_data), .word_full(word_full)
  );

  dac_ctrl_rx_out #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(word_done), .word(word_full),
    .code(dac_code), .valid(dac_valid)
  );
endmodule

// File: rtl/dac_ctrl_rx_chk.sv
module dac_ctrl_rx_chk #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_valid
);
  localparam int GAP_W = $clog2(WORD_W + 2) + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;
  localparam logic [GAP_W-1:0] MIN_GAP = GAP_W'(WORD_W + 1);

  logic [GAP_W-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= '0;
    else if (dac_valid) gap <= GAP_W'(1);
    else if (gap != GAP_MAX) gap <= gap + 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dac_code == '0) && !dac_valid);

  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid);

  // R5
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_valid |-> $stable(dac_code));

  // R9
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> gap >= MIN_GAP);
endmodule

bind dac_ctrl_rx dac_ctrl_rx_chk #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_code(dac_code), .dac_valid(dac_valid)
);

// File: tb/dac_ctrl_rx_test.sv
module dac_ctrl_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_sync = 1'b0;
  logic        ser_data = 1'b0;
  logic [11:0] dac_code;
  logic        dac_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dac_ctrl_rx uut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .ser_data(ser_data), .dac_code(dac_code), .dac_valid(dac_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Caller is at a falling edge. Raises sync for one edge, then shifts 16 bits.
  // noisy keeps sync high through every data edge; chain leaves sync high at the end.
  task automatic send_word(input logic [15:0] w, input bit noisy, input bit chain,
                           input string req);
    logic [11:0] prev;
    prev = dac_code;
    frame_sync = 1'b1;
    @(negedge clk);
    check({req, " R4 strobe low during capture"}, int'(dac_valid), 0);
    for (int i = 15; i >= 0; i--) begin
      frame_sync = noisy;
      ser_data = w[i];
      @(negedge clk);
      if (i != 0) begin
        check({req, " R4 strobe early"}, int'(dac_valid), 0);
        check({req, " R5 code held"}, int'(dac_code), int'(prev));
      end
    end
    frame_sync = chain;
    check({req, " R4 strobe"}, int'(dac_valid), 1);
    check({req, " R3 code"}, int'(dac_code), int'(w[11:0]));
  endtask

  task automatic t_reset;
    check("R1 code", int'(dac_code), 0);
    check("R1 valid", int'(dac_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 code after release", int'(dac_code), 0);
    check("R1 valid after release", int'(dac_valid), 0);
  endtask

  task automatic t_basic;
    send_word(16'h0A5C, 0, 0, "R2 basic");
    @(negedge clk);
    check("R4 strobe one cycle", int'(dac_valid), 0);
    check("R5 code kept", int'(dac_code), 12'hA5C);
  endtask

  task automatic t_upper_discard;
    send_word(16'hF123, 0, 0, "R3 upper set");
    @(negedge clk);
    send_word(16'hF000, 0, 0, "R3 only upper");
    @(negedge clk);
    send_word(16'h0FFF, 0, 0, "R2 msb first ones");
    @(negedge clk);
  endtask

  task automatic t_noisy_sync;
    logic [11:0] held;
    send_word(16'h8421, 1, 0, "R6 sync held");
    held = dac_code;
    for (int k = 0; k < 20; k++) begin
      ser_data = k[0];
      @(negedge clk);
      if (dac_valid) check("R6 no restart after noisy word", 1, 0);
    end
    check("R6 code after noisy word", int'(dac_code), int'(held));
  endtask

  task automatic t_back_to_back;
    send_word(16'h1357, 0, 1, "R7 first");
    send_word(16'h2468, 0, 1, "R7 second");
    send_word(16'h39AB, 0, 0, "R7 third");
    @(negedge clk);
    check("R9 strobe drops", int'(dac_valid), 0);
  endtask

  task automatic t_idle;
    logic [11:0] held;
    int strobes;
    held = dac_code;
    strobes = 0;
    frame_sync = 1'b0;
    for (int k = 0; k < 40; k++) begin
      ser_data = k[1] ^ k[0];
      @(negedge clk);
      if (dac_valid) strobes++;
    end
    check("R8 no strobe when idle", strobes, 0);
    check("R8 code unchanged when idle", int'(dac_code), int'(held));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_basic;
    t_upper_discard;
    t_noisy_sync;
    t_back_to_back;
    t_idle;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule